// File: doc/BRIEF.md
# Loop-Sum State Machine with Datapath

This block is the kind of hardware a C-to-gates compiler produces for a small function. The function builds a local integer array in an on-chip stack memory, walks over it with a counted loop, and returns the total of its elements. The array contents come from parameters: element `i` is `ELEM_BASE + i*ELEM_STEP`. The loop bound `LOOP_LIMIT` is compared as a signed number.

A single 32-bit state register drives two per-state case statements on every clock edge. One statement chooses the next state. The other updates at most one destination, which is a data register or the memory. A caller holds the block in reset, then raises `start` while the machine sits in its entry state. It then waits for the one-cycle `done` pulse and reads `ret`.

The stack memory is addressed by word. Every access forms a byte offset by addition and then divides it by four to get the word index.

Top module: `loop_sum_fsmd`

## Requirements
- R1: While `rst_n` is low at a clock edge, the state register is loaded with the entry (idle) state, numbered 20, and `done` and `ret` are cleared to 0. This works whatever value the state held before, including a value that no case lists. A state that no case lists changes no register until reset.
- R2: `start` is acted on only in the idle state, where it moves the machine to its first working state. A `start` seen in any other state has no effect on timing or results.
- R3: The array is filled so that word `(FRAME_BYTES + 4*i)/4` of the stack holds `ELEM_BASE + i*ELEM_STEP`, for i from 0 up to `LOOP_LIMIT-1`.
- R4: `ret` takes the sum of all filled elements, computed modulo 2^32 in two's complement, with both operands of every add 32 bits wide.
- R5: Both loop tests compare the index with `LOOP_LIMIT` as signed 32-bit values. A `LOOP_LIMIT` of zero or less runs no iterations and returns 0.
- R6: With n = max(`LOOP_LIMIT`,0), `ret` is updated at the (8+10n)-th clock edge after the edge that accepted `start`. `done` is high for exactly the one cycle after the (9+10n)-th edge. The machine is back in idle after edge 10+10n.
- R7: The stack memory sees at most one access (a read or a write) per cycle, and every byte address it is given is a multiple of four.
- R8: The two loop-test states change no data register. They only choose between their two successors.
- R9: Between the edge that loads a result and the same edge of the next run, `ret` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin one run when the machine is idle |
| done | output | 1 | One-cycle pulse when the result is ready |
| ret | output | DATA_W | Returned sum, held until the next run loads a new one |

## Verification
Assertions check on every cycle that:
- reset lands in the entry state and that `start` matters only there;
- unlisted states freeze;
- the loop-test states leave the data registers untouched;
- memory traffic is single-access and word-aligned;
- `done` never lasts two cycles;
- `ret` changes only when leaving the return state.

Only the bench's scenarios can show that the returned value is the right sum, and that the run takes the stated number of cycles. Those scenarios are a negative bit, a bound that makes the sum wrap, a start pulse during a run, a reset in the middle of a run, and a held start.

// File: rtl/lsum_pkg.sv
// Package: state numbering shared by the controller and the datapath.
// Assumes states count down from the entry state; every number fits in 32 bits.
package lsum_pkg;

    typedef logic [31:0] state_t;

    localparam state_t ST_IDLE = 32'd20;  // entry point, waits for start
    localparam state_t ST_ONE  = 32'd19;  // unit-step register := 1
    localparam state_t ST_FI0  = 32'd18;  // fill index := 0
    localparam state_t ST_FV0  = 32'd17;  // fill value := base
    localparam state_t ST_FCHK = 32'd16;  // fill loop test (control only)
    localparam state_t ST_FOFS = 32'd15;  // byte offset of element
    localparam state_t ST_FST  = 32'd14;  // store element to stack
    localparam state_t ST_FVAL = 32'd13;  // next fill value
    localparam state_t ST_FINC = 32'd12;  // fill index += 1
    localparam state_t ST_S0   = 32'd11;  // running sum := 0
    localparam state_t ST_RI0  = 32'd10;  // read index := 0
    localparam state_t ST_RCHK = 32'd9;   // read loop test (control only)
    localparam state_t ST_ROFS = 32'd8;   // byte offset of element
    localparam state_t ST_RLD  = 32'd7;   // load element from stack
    localparam state_t ST_ACC  = 32'd6;   // sum += element
    localparam state_t ST_RINC = 32'd5;   // read index += 1
    localparam state_t ST_RET  = 32'd4;   // return register := sum
    localparam state_t ST_FIN  = 32'd3;   // raise done
    localparam state_t ST_CLR  = 32'd2;   // drop done, back to idle

    // True for any state number that a case statement lists.
    function automatic logic is_listed(input state_t s);
        return (s >= ST_CLR) && (s <= ST_IDLE);
    endfunction

endpackage

// File: rtl/lsum_stack.sv
// Module: word-addressed stack memory for the function's local array.
// Single port: a write or a read per cycle, never both. The read is
// combinational and returns zero when no read is requested.
module lsum_stack #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              re,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    logic [DATA_W-1:0] words [DEPTH];

    // Write port: one word per cycle.
    always_ff @(posedge clk) begin
        if (we) begin
            words[addr] <= wdata;
        end
    end

    // Read port: gated so an idle port drives zero.
    always_comb begin
        rdata = re ? words[addr] : '0;
    end

    AST_ONE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        !(we && re)); // R7

endmodule

// File: rtl/lsum_ctrl.sv
// Module: control half of the machine. Holds the 32-bit state register and
// computes the next state per state. The loop tests live only here and compare
// signed. Unlisted states keep their value until reset.
module lsum_ctrl
    import lsum_pkg::*;
#(
    parameter int DATA_W            = 32,
    parameter int signed LOOP_LIMIT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [DATA_W-1:0] idx,
    output state_t            st_q
);

    localparam logic [DATA_W-1:0] LIMIT_W = DATA_W'(LOOP_LIMIT);

    logic idx_below;

    // Signed loop test; both operands are DATA_W wide.
    always_comb begin
        idx_below = $signed(idx) < $signed(LIMIT_W);
    end

    // State register: reset to entry, otherwise one case per state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            case (st_q)
                ST_IDLE: if (start) st_q <= ST_ONE;
                ST_ONE:  st_q <= ST_FI0;
                ST_FI0:  st_q <= ST_FV0;
                ST_FV0:  st_q <= ST_FCHK;
                ST_FCHK: st_q <= idx_below ? ST_FOFS : ST_S0;
                ST_FOFS: st_q <= ST_FST;
                ST_FST:  st_q <= ST_FVAL;
                ST_FVAL: st_q <= ST_FINC;
                ST_FINC: st_q <= ST_FCHK;
                ST_S0:   st_q <= ST_RI0;
                ST_RI0:  st_q <= ST_RCHK;
                ST_RCHK: st_q <= idx_below ? ST_ROFS : ST_RET;
                ST_ROFS: st_q <= ST_RLD;
                ST_RLD:  st_q <= ST_ACC;
                ST_ACC:  st_q <= ST_RINC;
                ST_RINC: st_q <= ST_RCHK;
                ST_RET:  st_q <= ST_FIN;
                ST_FIN:  st_q <= ST_CLR;
                ST_CLR:  st_q <= ST_IDLE;
                default: ;  // unknown state: no transition
            endcase
        end
    end

    AST_RESET_ENTRY: assert property (@(posedge clk)
        !rst_n |=> st_q == ST_IDLE); // R1

    AST_UNLISTED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !is_listed(st_q) |=> $stable(st_q)); // R1

    AST_START_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && start) |=> st_q == ST_ONE); // R2

    AST_IDLE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !start) |=> st_q == ST_IDLE); // R2

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> st_q != ST_ONE); // R2

endmodule

// File: rtl/lsum_dpath.sv
// Module: datapath half of the machine. Each state writes at most one
// destination (a register or the stack). Every operation uses equal widths.
// Stack addresses are byte offsets divided by four. Unlisted states and the
// loop-test states do nothing here.
module lsum_dpath
    import lsum_pkg::*;
#(
    parameter int DATA_W            = 32,
    parameter int signed ELEM_BASE  = -5,
    parameter int signed ELEM_STEP  = 3,
    parameter int FRAME_BYTES       = 8,
    parameter int AW                = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  state_t            st,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] idx,
    output logic              mem_we,
    output logic              mem_re,
    output logic [AW-1:0]     mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              done,
    output logic [DATA_W-1:0] ret
);

    localparam logic [DATA_W-1:0] BASE_W  = DATA_W'(ELEM_BASE);
    localparam logic [DATA_W-1:0] STEP_W  = DATA_W'(ELEM_STEP);
    localparam logic [DATA_W-1:0] FRAME_W = DATA_W'(FRAME_BYTES);
    localparam logic [DATA_W-1:0] FOUR_W  = DATA_W'(4);

    logic [DATA_W-1:0] r_one, r_i, r_val, r_ofs, r_elem, r_sum, r_ret;
    logic              r_fin;
    logic [DATA_W-1:0] byte_addr;

    // Stack address: frame offset plus element offset, then bytes to words.
    always_comb begin
        byte_addr = FRAME_W + r_ofs;
        mem_addr  = AW'(byte_addr / FOUR_W);
        mem_we    = (st == ST_FST);
        mem_re    = (st == ST_RLD);
        mem_wdata = r_val;
    end

    // Datapath map: one destination per listed state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_fin <= 1'b0;
            r_ret <= '0;
        end else begin
            case (st)
                ST_ONE:  r_one  <= DATA_W'(1);
                ST_FI0:  r_i    <= '0;
                ST_FV0:  r_val  <= BASE_W;
                ST_FCHK: ;  // test only, control side
                ST_FOFS: r_ofs  <= {r_i[DATA_W-3:0], 2'b00};
                ST_FVAL: r_val  <= r_val + STEP_W;
                ST_FINC: r_i    <= r_i + r_one;
                ST_S0:   r_sum  <= '0;
                ST_RI0:  r_i    <= '0;
                ST_RCHK: ;  // test only, control side
                ST_ROFS: r_ofs  <= {r_i[DATA_W-3:0], 2'b00};
                ST_RLD:  r_elem <= mem_rdata;
                ST_ACC:  r_sum  <= r_sum + r_elem;
                ST_RINC: r_i    <= r_i + r_one;
                ST_RET:  r_ret  <= r_sum;
                ST_FIN:  r_fin  <= 1'b1;
                ST_CLR:  r_fin  <= 1'b0;
                default: ;  // idle, store or unknown: no register update
            endcase
        end
    end

    assign idx  = r_i;
    assign done = r_fin;
    assign ret  = r_ret;

    AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we || mem_re) |-> byte_addr[1:0] == 2'b00); // R7

    AST_BRANCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_FCHK || st == ST_RCHK) |=>
            ($stable(r_i) && $stable(r_sum) && $stable(r_val) && $stable(r_ret))); // R8

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R6

    AST_DONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> st == ST_CLR); // R6

    AST_RET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st != ST_RET) |=> $stable(ret)); // R9

endmodule

// File: rtl/loop_sum_fsmd.sv
// Module: top of the loop-sum machine. Ties the controller, datapath and
// stack memory to one state register. Assumes FRAME_BYTES is a multiple of
// four and that the array fits in DEPTH words.
module loop_sum_fsmd
    import lsum_pkg::*;
#(
    parameter int DATA_W            = 32,
    parameter int signed LOOP_LIMIT = 3,
    parameter int signed ELEM_BASE  = -5,
    parameter int signed ELEM_STEP  = 3,
    parameter int FRAME_BYTES       = 8,
    parameter int DEPTH             = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              done,
    output logic [DATA_W-1:0] ret
);

    localparam int AW = $clog2(DEPTH);

    state_t            st;
    logic [DATA_W-1:0] idx;
    logic              mem_we, mem_re;
    logic [AW-1:0]     mem_addr;
    logic [DATA_W-1:0] mem_wdata, mem_rdata;

    lsum_ctrl #(
        .DATA_W    (DATA_W),
        .LOOP_LIMIT(LOOP_LIMIT)
    ) u_ctrl (
        .clk  (clk),
        .rst_n(rst_n),
        .start(start),
        .idx  (idx),
        .st_q (st)
    );

    lsum_dpath #(
        .DATA_W     (DATA_W),
        .ELEM_BASE  (ELEM_BASE),
        .ELEM_STEP  (ELEM_STEP),
        .FRAME_BYTES(FRAME_BYTES),
        .AW         (AW)
    ) u_dpath (
        .clk      (clk),
        .rst_n    (rst_n),
        .st       (st),
        .mem_rdata(mem_rdata),
        .idx      (idx),
        .mem_we   (mem_we),
        .mem_re   (mem_re),
        .mem_addr (mem_addr),
        .mem_wdata(mem_wdata),
        .done     (done),
        .ret      (ret)
    );

    lsum_stack #(
        .DATA_W(DATA_W),
        .DEPTH (DEPTH)
    ) u_stack (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (mem_we),
        .re   (mem_re),
        .addr (mem_addr),
        .wdata(mem_wdata),
        .rdata(mem_rdata)
    );

endmodule

// File: tb/loop_sum_fsmd_tb.sv
// Behavioural reference: counts edges after an accepted start and predicts
// done and ret from the requirements alone.
module lsum_ref #(
    parameter int signed LIM  = 3,
    parameter int signed BASE = -5,
    parameter int signed STEP = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    output logic        exp_done,
    output logic [31:0] exp_ret,
    output logic [31:0] exp_sum
);
    int n;
    int cnt;

    initial begin
        logic [31:0] v;
        n = (LIM > 0) ? LIM : 0;
        v = 32'(BASE);
        exp_sum = '0;
        for (int i = 0; i < n; i++) begin
            exp_sum = exp_sum + v;
            v = v + 32'(STEP);
        end
        cnt = -1;
        exp_done = 1'b0;
        exp_ret = '0;
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            cnt = -1;
            exp_done = 1'b0;
            exp_ret = '0;
        end else if (cnt < 0) begin
            if (start) cnt = 0;
        end else begin
            cnt = cnt + 1;
            if (cnt == 8 + 10 * n) exp_ret = exp_sum;
            if (cnt == 9 + 10 * n) exp_done = 1'b1;
            if (cnt == 10 + 10 * n) begin
                exp_done = 1'b0;
                cnt = -1;
            end
        end
    end
endmodule

module loop_sum_fsmd_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    always #10 clk = ~clk;  // 50 MHz

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit cmp_en = 1'b0;
    string phase = "R1";

    logic        d_a, d_b, d_c, e_da, e_db, e_dc;
    logic [31:0] r_a, r_b, r_c, e_ra, e_rb, e_rc, s_a, s_b, s_c;

    // A: small mixed-sign array; B: sum wraps; C: negative bound.
    loop_sum_fsmd u_dut (.clk(clk), .rst_n(rst_n), .start(start), .done(d_a), .ret(r_a));
    loop_sum_fsmd #(.LOOP_LIMIT(5), .ELEM_BASE(2147483000), .ELEM_STEP(100)) u_dut_wrap
        (.clk(clk), .rst_n(rst_n), .start(start), .done(d_b), .ret(r_b));
    loop_sum_fsmd #(.LOOP_LIMIT(-2), .ELEM_BASE(9), .ELEM_STEP(1)) u_dut_neg
        (.clk(clk), .rst_n(rst_n), .start(start), .done(d_c), .ret(r_c));

    lsum_ref m_a (.clk(clk), .rst_n(rst_n), .start(start), .exp_done(e_da), .exp_ret(e_ra), .exp_sum(s_a));
    lsum_ref #(.LIM(5), .BASE(2147483000), .STEP(100)) m_b
        (.clk(clk), .rst_n(rst_n), .start(start), .exp_done(e_db), .exp_ret(e_rb), .exp_sum(s_b));
    lsum_ref #(.LIM(-2), .BASE(9), .STEP(1)) m_c
        (.clk(clk), .rst_n(rst_n), .start(start), .exp_done(e_dc), .exp_ret(e_rc), .exp_sum(s_c));

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // Per-cycle comparison against the reference (R6 timing, R4 value).
    always @(negedge clk) begin
        if (cmp_en) begin
            chk(d_a === e_da, "R6", {phase, " done A"}, 32'(d_a), 32'(e_da));
            chk(d_b === e_db, "R6", {phase, " done B"}, 32'(d_b), 32'(e_db));
            chk(d_c === e_dc, "R6", {phase, " done C"}, 32'(d_c), 32'(e_dc));
            chk(r_a === e_ra, "R4", {phase, " ret A"}, r_a, e_ra);
            chk(r_b === e_rb, "R4", {phase, " ret B"}, r_b, e_rb);
            chk(r_c === e_rc, "R4", {phase, " ret C"}, r_c, e_rc);
        end
    end

    // Watchdog: a hang counts as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            tests++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under 20000", cyc);
            finish_run();
        end
    end

    task automatic pulse_start();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic check_sums(input string tag);
        chk(r_a === 32'hFFFF_FFFA, "R3", {tag, " A sum -6, R7 word stack"}, r_a, 32'hFFFF_FFFA);
        chk(r_b === s_b, "R4", {tag, " B wrapped sum"}, r_b, s_b);
        chk(r_c === 32'd0, "R5", {tag, " C no iterations, R8"}, r_c, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state observed at the ports.
        chk(d_a === 1'b0 && d_b === 1'b0 && d_c === 1'b0, "R1", "done in reset", 32'(d_a | d_b | d_c), 0);
        chk(r_a === 0 && r_b === 0 && r_c === 0, "R1", "ret in reset", r_a | r_b | r_c, 0);
        cmp_en = 1'b1;
        @(negedge clk) rst_n = 1'b1;

        // R2: a start during a run is ignored.
        phase = "R2";
        repeat (4) @(negedge clk);
        pulse_start();
        repeat (7) @(negedge clk);
        pulse_start();
        repeat (70) @(negedge clk);
        check_sums("R2 run1");

        // R9: result held while idle.
        phase = "R9";
        repeat (20) @(negedge clk);
        chk(r_a === 32'hFFFF_FFFA, "R9", "A held", r_a, 32'hFFFF_FFFA);

        // R1: reset in the middle of a run, then a clean run.
        phase = "R1";
        pulse_start();
        repeat (15) @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(r_a === 0 && d_a === 1'b0, "R1", "mid-run reset clears", r_a, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        pulse_start();
        repeat (70) @(negedge clk);
        check_sums("R1 rerun");

        // R6: start held high gives back-to-back runs from idle.
        phase = "R6";
        @(negedge clk) start = 1'b1;
        repeat (150) @(negedge clk);
        start = 1'b0;
        repeat (70) @(negedge clk);
        check_sums("R6 held");

        finish_run();
    end
endmodule